// File: doc/BRIEF.md
# Reversible Full-Range Address Sequencer

This block produces the address stream for a memory self-test engine. It is a shift register whose feedback follows a primitive polynomial, with one extra correction term. That term is the NOR of every stage except the one being shifted out. It splices the all-zero state into the cycle, so a register of width W steps through all 2^W addresses, not just 2^W - 1.

Each stage takes its next value through a two-input select. In forward mode the stage loads its lower neighbour and the lowest stage loads the forward feedback. In reverse mode the stage loads its upper neighbour and the highest stage loads the feedback of the reciprocal polynomial. A single control input therefore runs the same register along the same cycle in either direction. A march element that sweeps upward and one that sweeps downward visit the addresses in exactly opposite orders, and both start from zero.

The controller uses the decoded flags to close a march element. One flag marks the start address. One marks the final address of an upward sweep, one marks the final address of a downward sweep, and one marks the final address for the direction currently selected.

Top module: `udlag_addr_gen`

## Requirements
- R1: An active-low asynchronous reset forces addr to 0, and at_origin is 1 while reset is held.
- R2: While step_en is 0, addr keeps its value whatever dir_down does.
- R3: With ADDR_W = 3, dir_down = 0 and step_en = 1, addr (bit 0 is the first stage) takes the values 0, 1, 3, 7, 6, 5, 2, 4 and then 0 again.
- R4: With ADDR_W = 3, dir_down = 1 and step_en = 1, addr takes the values 0, 4, 2, 5, 6, 7, 3, 1 and then 0 again.
- R5: For every ADDR_W from 3 to 16, starting at 0, an unbroken run of enabled steps in one direction first returns to 0 after exactly 2^ADDR_W steps. This holds in both directions.
- R6: The direction may change on any enabled cycle. A downward step undoes the upward step just before it, and an upward step undoes the downward step just before it.
- R7: at_origin is 1 exactly when addr is 0.
- R8: end_up is 1 exactly when only bit ADDR_W-1 of addr is set. end_down is 1 exactly when only bit 0 is set. At most one of at_origin, end_up and end_down is 1.
- R9: end_now equals end_down when dir_down is 1 and end_up otherwise. An enabled step taken while end_now is 1 leads to addr 0.
- R10: An enabled upward step from 0 gives addr 1. An enabled downward step from 0 gives addr with only bit ADDR_W-1 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Advance one state on this edge |
| dir_down | input | 1 | 1 selects the reverse (reciprocal) sequence |
| addr | output | ADDR_W | Current address |
| at_origin | output | 1 | addr is the start state 0 |
| end_up | output | 1 | addr is the final state of an upward sweep |
| end_down | output | 1 | addr is the final state of a downward sweep |
| end_now | output | 1 | addr is the final state for the selected direction |

## Verification
Four properties are checked on every clock:
- the hold under a low enable;
- the wrap to zero from any final state;
- the exit from zero in each direction;
- a reversal returning to the address of two cycles earlier.

The mutual exclusion of the three decoded flags is also checked on every clock. Other behaviours can only be shown by the bench's runs: the exact 3-bit orders, the full 2^W period at every width, and the fact that no address repeats early. The bench runs a separate instance for each width from 3 to 16. Each instance does a full sweep in both directions, then a window of alternating forward and reverse steps.

// File: rtl/udlag_pkg.sv
package udlag_pkg;

   localparam int MIN_W = 3;
   localparam int MAX_W = 16;

   typedef enum logic {
      DIR_FWD = 1'b0,
      DIR_REV = 1'b1
   } udlag_dir_e;

   // Feedback taps (besides the top stage) for the forward recurrence
   // next[0] = s[W-1] ^ XOR(s & mask) ^ NOR(s[W-2:0]).
   function automatic logic [MAX_W-1:0] tap_mask(input int w);
      case (w)
         3:       return 16'h0001;
         4:       return 16'h0001;
         5:       return 16'h0002;
         6:       return 16'h0001;
         7:       return 16'h0001;
         8:       return 16'h000E;
         9:       return 16'h0008;
         10:      return 16'h0004;
         11:      return 16'h0002;
         12:      return 16'h04A0;
         13:      return 16'h0B00;
         14:      return 16'h1500;
         15:      return 16'h0001;
         16:      return 16'h0805;
         default: return 16'h0000;
      endcase
   endfunction

endpackage

// File: rtl/udlag_feedback.sv
module udlag_feedback
   import udlag_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] state,
   output logic              fwd_bit,
   output logic              rev_bit
);

   localparam logic [MAX_W-1:0] FULL_MASK = tap_mask(ADDR_W);
   localparam logic [ADDR_W-1:0] TAPS     = FULL_MASK[ADDR_W-1:0];

   if (TAPS == '0) begin : g_bad_taps
      $error("udlag_feedback: no tap entry for ADDR_W=%0d", ADDR_W);
   end
   if (TAPS[ADDR_W-1]) begin : g_bad_top
      $error("udlag_feedback: tap mask must not include the top stage");
   end

   logic [ADDR_W-1:0] up_shifted;
   logic              fwd_taps;
   logic              rev_taps;
   logic              fwd_zero_fix;
   logic              rev_zero_fix;

   // Taps as seen one position higher after a forward shift.
   assign up_shifted   = state >> 1;
   assign fwd_taps     = ^(state & TAPS);
   assign rev_taps     = ^(up_shifted & TAPS);
   // Zero-state splice: all stages except the outgoing one are clear.
   assign fwd_zero_fix = ~|state[ADDR_W-2:0];
   assign rev_zero_fix = ~|state[ADDR_W-1:1];

   assign fwd_bit = state[ADDR_W-1] ^ fwd_taps ^ fwd_zero_fix;
   assign rev_bit = state[0] ^ rev_taps ^ rev_zero_fix;

endmodule

// File: rtl/udlag_stage.sv
module udlag_stage #(
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step_en,
   input  logic dir_down,
   input  logic fwd_in,
   input  logic rev_in,
   output logic q
);

   logic d_sel;

   // Per-stage path select: lower neighbour going forward, upper going back.
   assign d_sel = dir_down ? rev_in : fwd_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RESET_VAL;
      end else if (step_en) begin
         q <= d_sel;
      end
   end

endmodule

// File: rtl/udlag_term.sv
module udlag_term #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] state,
   input  logic              dir_down,
   output logic              at_origin,
   output logic              end_up,
   output logic              end_down,
   output logic              end_now
);

   localparam logic [ADDR_W-1:0] UP_LAST = {1'b1, {(ADDR_W-1){1'b0}}};
   localparam logic [ADDR_W-1:0] DN_LAST = {{(ADDR_W-1){1'b0}}, 1'b1};

   assign at_origin = (state == '0);
   assign end_up    = (state == UP_LAST);
   assign end_down  = (state == DN_LAST);
   assign end_now   = dir_down ? end_down : end_up;

   // R8: the three decoded positions never coincide.
   p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({at_origin, end_up, end_down}));

endmodule

// File: rtl/udlag_addr_gen.sv
module udlag_addr_gen
   import udlag_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic              dir_down,
   output logic [ADDR_W-1:0] addr,
   output logic              at_origin,
   output logic              end_up,
   output logic              end_down,
   output logic              end_now
);

   localparam int TOP = ADDR_W - 1;
   localparam logic [ADDR_W-1:0] UP_FIRST = {{(ADDR_W-1){1'b0}}, 1'b1};
   localparam logic [ADDR_W-1:0] DN_FIRST = {1'b1, {(ADDR_W-1){1'b0}}};

   if (ADDR_W < MIN_W || ADDR_W > MAX_W) begin : g_bad_width
      $error("udlag_addr_gen: ADDR_W=%0d outside %0d..%0d", ADDR_W, MIN_W, MAX_W);
   end

   logic [ADDR_W-1:0] state;
   logic [ADDR_W-1:0] fwd_src;
   logic [ADDR_W-1:0] rev_src;
   logic              fwd_bit;
   logic              rev_bit;

   udlag_feedback #(.ADDR_W(ADDR_W)) u_fb (
      .state   (state),
      .fwd_bit (fwd_bit),
      .rev_bit (rev_bit)
   );

   for (genvar i = 0; i < ADDR_W; i++) begin : g_stage
      if (i == 0) begin : g_low
         assign fwd_src[i] = fwd_bit;
      end else begin : g_mid_f
         assign fwd_src[i] = state[i-1];
      end
      if (i == TOP) begin : g_high
         assign rev_src[i] = rev_bit;
      end else begin : g_mid_r
         assign rev_src[i] = state[i+1];
      end
      udlag_stage #(.RESET_VAL(1'b0)) u_st (
         .clk      (clk),
         .rst_n    (rst_n),
         .step_en  (step_en),
         .dir_down (dir_down),
         .fwd_in   (fwd_src[i]),
         .rev_in   (rev_src[i]),
         .q        (state[i])
      );
   end

   udlag_term #(.ADDR_W(ADDR_W)) u_term (
      .clk       (clk),
      .rst_n     (rst_n),
      .state     (state),
      .dir_down  (dir_down),
      .at_origin (at_origin),
      .end_up    (end_up),
      .end_down  (end_down),
      .end_now   (end_now)
   );

   assign addr = state;

   // R2: no movement without an enable.
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(addr));

   // R9: stepping off a final state always lands on zero.
   p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      step_en && end_now |=> addr == '0);

   // R10: leaving zero in each direction.
   p_exit_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
      step_en && at_origin && !dir_down |=> addr == UP_FIRST);
   p_exit_dn_r10: assert property (@(posedge clk) disable iff (!rst_n)
      step_en && at_origin && dir_down |=> addr == DN_FIRST);

   // R6: a step in the opposite direction restores the earlier address.
   p_undo_r6: assert property (@(posedge clk) disable iff (!rst_n)
      step_en && $past(step_en) && $past(rst_n) && (dir_down != $past(dir_down))
      |=> addr == $past(addr, 2));

endmodule

// File: tb/udlag_addr_gen_tb.sv
module udlag_addr_gen_tb;

   localparam int LO_W    = 3;
   localparam int HI_W    = 16;
   localparam int N_SWEEP = HI_W - LO_W + 1;
   localparam int N_VEC   = 30;

   // Vector: {tag[1:0], en, dn, exp[2:0]}; tag 0=R3 1=R4 2=R6 3=R2.
   localparam logic [6:0] VEC [N_VEC] = '{
      7'b00_10_001, 7'b00_10_011, 7'b00_10_111, 7'b00_10_110,
      7'b00_10_101, 7'b00_10_010, 7'b00_10_100, 7'b00_10_000,
      7'b11_01_000, 7'b11_00_000,
      7'b01_11_100, 7'b01_11_010, 7'b01_11_101, 7'b01_11_110,
      7'b01_11_111, 7'b01_11_011, 7'b01_11_001, 7'b01_11_000,
      7'b10_10_001, 7'b10_10_011, 7'b10_11_001, 7'b11_00_001,
      7'b11_01_001, 7'b10_10_011, 7'b10_10_111, 7'b10_11_011,
      7'b10_11_001, 7'b10_11_000, 7'b10_11_100, 7'b10_10_000
   };

   logic clk    = 1'b0;
   logic rst_n  = 1'b1;
   logic rst3_n = 1'b1;
   always #10 clk = ~clk;

   int n_tests     = 0;
   int n_fail      = 0;
   int sweeps_done = 0;
   bit main_done   = 1'b0;
   bit reported    = 1'b0;
   bit sweep_go    = 1'b0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   logic       en3 = 1'b0;
   logic       dn3 = 1'b0;
   logic [2:0] addr3;
   logic       org3, eu3, ed3, now3;

   udlag_addr_gen #(.ADDR_W(3)) u_dut (
      .clk       (clk),
      .rst_n     (rst3_n),
      .step_en   (en3),
      .dir_down  (dn3),
      .addr      (addr3),
      .at_origin (org3),
      .end_up    (eu3),
      .end_down  (ed3),
      .end_now   (now3)
   );

   for (genvar gw = LO_W; gw <= HI_W; gw++) begin : g_sweep
      localparam int N    = 1 << gw;
      localparam int NREV = (N < 4096) ? N : 4096;
      logic          en_s = 1'b0;
      logic          dn_s = 1'b0;
      logic [gw-1:0] a_s;
      logic          o_s, eu_s, ed_s, nw_s;

      udlag_addr_gen #(.ADDR_W(gw)) u_sw (
         .clk       (clk),
         .rst_n     (rst_n),
         .step_en   (en_s),
         .dir_down  (dn_s),
         .addr      (a_s),
         .at_origin (o_s),
         .end_up    (eu_s),
         .end_down  (ed_s),
         .end_now   (nw_s)
      );

      initial begin
         int            bad_p;
         int            bad_f;
         logic [gw-1:0] prev;
         logic [gw-1:0] nxt;
         wait (sweep_go);
         @(negedge clk);
         // R5 / R8 / R9 upward sweep
         bad_p = 0; bad_f = 0;
         for (int k = 0; k < N; k++) begin
            if (eu_s != (k == N-1) || nw_s != (k == N-1) || ed_s != (k == 1)) bad_f++;
            en_s = 1'b1; dn_s = 1'b0;
            @(negedge clk);
            if ((a_s == '0) != (k == N-1)) bad_p++;
         end
         chk(bad_p == 0, $sformatf("R5 up period W=%0d", gw), longint'(bad_p), 0);
         chk(bad_f == 0, $sformatf("R8 R9 up flags W=%0d", gw), longint'(bad_f), 0);
         // R5 / R8 / R9 downward sweep
         bad_p = 0; bad_f = 0;
         for (int k = 0; k < N; k++) begin
            dn_s = 1'b1;
            #1;
            if (ed_s != (k == N-1) || nw_s != (k == N-1) || eu_s != (k == 1)) bad_f++;
            @(negedge clk);
            if ((a_s == '0) != (k == N-1)) bad_p++;
         end
         chk(bad_p == 0, $sformatf("R5 down period W=%0d", gw), longint'(bad_p), 0);
         chk(bad_f == 0, $sformatf("R8 R9 down flags W=%0d", gw), longint'(bad_f), 0);
         // R6 alternating reversal window
         bad_p = 0;
         for (int k = 0; k < NREV; k++) begin
            prev = a_s;
            dn_s = 1'b0; @(negedge clk); nxt = a_s;
            dn_s = 1'b1; @(negedge clk);
            if (a_s != prev) bad_p++;
            @(negedge clk);
            dn_s = 1'b0; @(negedge clk);
            if (a_s != prev) bad_p++;
            @(negedge clk);
            if (a_s != nxt) bad_p++;
         end
         en_s = 1'b0;
         chk(bad_p == 0, $sformatf("R6 reversal W=%0d", gw), longint'(bad_p), 0);
         sweeps_done++;
      end
   end

   initial begin
      #1;
      rst_n  = 1'b0;
      rst3_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(addr3 == 3'd0, "R1 reset addr", longint'(addr3), 0);
      chk(org3 == 1'b1, "R1 R7 reset origin flag", longint'(org3), 1);
      rst_n  = 1'b1;
      rst3_n = 1'b1;
      sweep_go = 1'b1;
      dn3 = 1'b1;
      @(negedge clk);
      chk(addr3 == 3'd0, "R2 idle after reset", longint'(addr3), 0);

      for (int i = 0; i < N_VEC; i++) begin
         logic [2:0] ex;
         string      tag;
         ex  = VEC[i][2:0];
         en3 = VEC[i][4];
         dn3 = VEC[i][3];
         case (VEC[i][6:5])
            2'd0:    tag = "R3";
            2'd1:    tag = "R4";
            2'd2:    tag = "R6";
            default: tag = "R2";
         endcase
         @(negedge clk);
         chk(addr3 == ex, $sformatf("%s vec %0d addr", tag, i), longint'(addr3), longint'(ex));
         chk(org3 == (ex == 3'd0), $sformatf("R7 vec %0d", i), longint'(org3), longint'(ex == 3'd0));
         chk(eu3 == (ex == 3'd4) && ed3 == (ex == 3'd1),
             $sformatf("R8 vec %0d", i), longint'({eu3, ed3}), longint'({ex == 3'd4, ex == 3'd1}));
         chk(now3 == (dn3 ? (ex == 3'd1) : (ex == 3'd4)),
             $sformatf("R9 vec %0d", i), longint'(now3), longint'(dn3 ? (ex == 3'd1) : (ex == 3'd4)));
      end

      // R1: reset in the middle of a run
      en3 = 1'b1; dn3 = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(addr3 == 3'd3, "R3 before mid-run reset", longint'(addr3), 3);
      rst3_n = 1'b0;
      #1;
      chk(addr3 == 3'd0, "R1 async clear", longint'(addr3), 0);
      @(negedge clk);
      chk(addr3 == 3'd0, "R1 held in reset with enable", longint'(addr3), 0);
      rst3_n = 1'b1;
      @(negedge clk);
      chk(addr3 == 3'd1, "R10 up exit from 0", longint'(addr3), 1);
      dn3 = 1'b1;
      @(negedge clk);
      chk(addr3 == 3'd0, "R6 back to 0", longint'(addr3), 0);
      @(negedge clk);
      chk(addr3 == 3'd4, "R10 down exit from 0", longint'(addr3), 4);
      en3 = 1'b0;
      dn3 = 1'b0;
      @(negedge clk);
      chk(addr3 == 3'd4 && eu3 == 1'b1, "R2 R8 hold at up-final", longint'(addr3), 4);
      main_done = 1'b1;

      wait (main_done && sweeps_done == N_SWEEP);
      @(negedge clk);
      report();
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d sweeps done", sweeps_done, N_SWEEP);
      report();
   end

endmodule